// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a down-counting watchdog that escalates in two steps. When the counter first runs out, it raises a timeout flag and a management interrupt request. It then restarts itself from the programmed reload value. Software is expected to clear the flag and kick the counter in time. If nothing kicks it before it runs out again, the block raises a second-timeout flag. When reboot is enabled, it also asserts a platform reset request, which stays high until the platform reset arrives.

The counter decrements once every `PRESCALE` pulses of the `tick_in` strobe, so the expiry period can be scaled. The second-timeout flag lives in the power-on reset domain, and so does a small boot-policy field. The platform reset that the block itself requests clears neither of them, so boot software can tell a watchdog reboot from a normal start. Software reaches the block through a small register port. Writes take effect on the clock edge. Reads return data combinationally from the address.

The register map is as follows:
- Address 0 is the reload value.
- Address 1 is the kick register. A write reloads the counter; a read returns the live count.
- Address 2 is control: bit 0 halt, bit 1 reboot enable, bits 7:4 boot policy.
- Address 3 is status: bit 0 timeout, bit 1 second timeout. Both bits are write-one-to-clear.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-on reset the count reads `RELOAD_DEF`, status reads 0, control reads 0, and both `mgmt_irq` and `plat_rst_req` are low.
- R2: While not halted, the count drops by exactly one for every `PRESCALE` pulses of `tick_in`. Fewer pulses leave it unchanged.
- R3: A counter tick that arrives when the count is 0 and the block is in its first stage is the first expiry. It sets status bit 0, drives `mgmt_irq` high and reloads the count from the reload value. Starting from a kick with reload value N, this happens on counter tick N+1.
- R4: Writing 1 to status bit 0 clears it and drops `mgmt_irq`. Writing 0 there leaves it set.
- R5: Any write to address 1 loads the count from the reload value, restarts the prescaler and returns the block to its first stage. A later expiry is then again a first expiry.
- R6: A counter tick at count 0 after a first expiry, with no kick in between, is the second expiry. It sets status bit 1.
- R7: On a second expiry `plat_rst_req` goes high only when control bit 1 (reboot enable) is set. Once high, it stays high until the platform reset `rst_n` is applied.
- R8: Status bit 1 survives `rst_n`. Only a write of 1 to it or a power-on reset `por_n` clears it.
- R9: While control bit 0 (halt) is set, the count does not change on ticks and neither status bit is cleared.
- R10: The platform reset clears the reload value, halt and reboot enable, but keeps the boot-policy field in control bits 7:4. Power-on reset clears that field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears every flop |
| rst_n | input | 1 | Platform reset, active low, spares the sticky domain |
| tick_in | input | 1 | Base time strobe, one cycle per pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W | Register read data, combinational |
| mgmt_irq | output | 1 | Management interrupt request after first expiry |
| plat_rst_req | output | 1 | Platform reset request after second expiry |

## Verification
On every cycle, the assertions check the single-step decrement, the frozen count while halted, and that each expiry pulse sets its flag on the next edge. They also check that the reset request rises only after a second expiry with reboot enabled and then holds. Only the directed scenarios can show the rest:
- the exact tick count from a kick to each expiry, and that a kick returns the block to its first stage;
- that write-one-to-clear ignores zeros;
- which state survives a platform reset but not a power-on reset, since those outcomes depend on sequences of register writes and resets.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_KICK   = 2'd1,
        REG_CTRL   = 2'd2,
        REG_STAT   = 2'd3
    } wd_addr_e;

    localparam int CTRL_HALT_BIT = 0;
    localparam int CTRL_RBT_BIT  = 1;
    localparam int POL_LSB       = 4;
    localparam int POL_W         = 4;
    localparam int STAT_TO_BIT   = 0;
    localparam int STAT_SEC_BIT  = 1;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick_in,
    output logic tick_en
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          pulse;
    } pre_t;

    pre_t pre_d, pre_q;

    generate
        if (PRESCALE > 1) begin : g_div
            always_comb begin
                pre_d       = pre_q;
                pre_d.pulse = 1'b0;
                if (clr) begin
                    pre_d.cnt = '0;
                end else if (tick_in) begin
                    if (pre_q.cnt == PW'(PRESCALE - 1)) begin
                        pre_d.cnt   = '0;
                        pre_d.pulse = 1'b1;
                    end else begin
                        pre_d.cnt = pre_q.cnt + 1'b1;
                    end
                end
            end
        end else begin : g_pass
            always_comb begin
                pre_d.cnt   = '0;
                pre_d.pulse = tick_in && !clr;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick_en = pre_q.pulse;

    p_pulse_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick_en) |-> $past(tick_in));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int CNT_W = 16,
    parameter logic [CNT_W-1:0] RELOAD_DEF = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halt,
    input  logic             kick,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             exp_first,
    output logic             exp_second
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stage2;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        exp_first  = 1'b0;
        exp_second = 1'b0;
        if (kick) begin
            cnt_d.cnt    = reload_val;
            cnt_d.stage2 = 1'b0;
        end else if (tick_en && !halt) begin
            if (cnt_q.cnt == '0) begin
                cnt_d.cnt = reload_val;
                if (!cnt_q.stage2) begin
                    exp_first    = 1'b1;
                    cnt_d.stage2 = 1'b1;
                end else begin
                    exp_second = 1'b1;
                end
            end else begin
                cnt_d.cnt = cnt_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.cnt    <= RELOAD_DEF;
            cnt_q.stage2 <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q.cnt;

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !halt && !kick && count != '0) |=> count == $past(count) - 1'b1);
    p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !kick) |=> $stable(count));
    p_kick_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> count == $past(reload_val));
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
    input  logic       clk,
    input  logic       plat_rst_n,
    input  logic       por_n,
    input  logic       exp_first,
    input  logic       exp_second,
    input  logic       reboot_en,
    input  logic [1:0] clr_mask,
    output logic       to_flag,
    output logic       sec_flag,
    output logic       rst_req
);
    typedef struct packed {
        logic to;
        logic req;
    } plat_t;

    plat_t plat_d, plat_q;
    logic  sec_d, sec_q;

    always_comb begin
        plat_d.to  = (plat_q.to & ~clr_mask[0]) | exp_first;
        plat_d.req = plat_q.req | (exp_second & reboot_en);
        sec_d      = (sec_q & ~clr_mask[1]) | exp_second;
    end

    always_ff @(posedge clk or negedge plat_rst_n) begin
        if (!plat_rst_n) plat_q <= '0;
        else             plat_q <= plat_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sec_q <= 1'b0;
        else        sec_q <= sec_d;
    end

    assign to_flag  = plat_q.to;
    assign sec_flag = sec_q;
    assign rst_req  = plat_q.req;

    p_first_sets_r3: assert property (@(posedge clk) disable iff (!plat_rst_n)
        exp_first |=> to_flag);
    p_second_sets_r6: assert property (@(posedge clk) disable iff (!plat_rst_n)
        exp_second |=> sec_flag);
    p_req_cause_r7: assert property (@(posedge clk) disable iff (!plat_rst_n)
        $rose(rst_req) |-> $past(exp_second && reboot_en));
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!plat_rst_n)
        rst_req |=> rst_req);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRESCALE = 4,
    parameter logic [CNT_W-1:0] RELOAD_DEF = CNT_W'(100)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             mgmt_irq,
    output logic             plat_rst_req
);
    localparam int CTRL_W = POL_LSB + POL_W;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             halt;
        logic             reboot_en;
    } cfg_t;

    logic plat_rst_n;
    assign plat_rst_n = rst_n & por_n;

    cfg_t             cfg_d, cfg_q;
    logic [POL_W-1:0] pol_d, pol_q;
    logic             kick, tick_en, exp_first, exp_second;
    logic             to_flag, sec_flag;
    logic [1:0]       clr_mask;
    logic [CNT_W-1:0] count;

    always_comb begin
        cfg_d    = cfg_q;
        pol_d    = pol_q;
        kick     = 1'b0;
        clr_mask = 2'b00;
        if (wr_en) begin
            case (wd_addr_e'(wr_addr))
                REG_RELOAD: cfg_d.reload = wr_data;
                REG_KICK:   kick = 1'b1;
                REG_CTRL: begin
                    cfg_d.halt      = wr_data[CTRL_HALT_BIT];
                    cfg_d.reboot_en = wr_data[CTRL_RBT_BIT];
                    pol_d           = wr_data[POL_LSB +: POL_W];
                end
                REG_STAT: clr_mask = {wr_data[STAT_SEC_BIT], wr_data[STAT_TO_BIT]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge plat_rst_n) begin
        if (!plat_rst_n) begin
            cfg_q.reload    <= RELOAD_DEF;
            cfg_q.halt      <= 1'b0;
            cfg_q.reboot_en <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pol_q <= '0;
        else        pol_q <= pol_d;
    end

    wdog_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (plat_rst_n),
        .clr     (kick),
        .tick_in (tick_in),
        .tick_en (tick_en)
    );

    wdog_counter #(.CNT_W(CNT_W), .RELOAD_DEF(RELOAD_DEF)) u_cnt (
        .clk        (clk),
        .rst_n      (plat_rst_n),
        .tick_en    (tick_en),
        .halt       (cfg_q.halt),
        .kick       (kick),
        .reload_val (cfg_q.reload),
        .count      (count),
        .exp_first  (exp_first),
        .exp_second (exp_second)
    );

    wdog_status u_stat (
        .clk        (clk),
        .plat_rst_n (plat_rst_n),
        .por_n      (por_n),
        .exp_first  (exp_first),
        .exp_second (exp_second),
        .reboot_en  (cfg_q.reboot_en),
        .clr_mask   (clr_mask),
        .to_flag    (to_flag),
        .sec_flag   (sec_flag),
        .rst_req    (plat_rst_req)
    );

    always_comb begin
        rd_data = '0;
        case (wd_addr_e'(rd_addr))
            REG_RELOAD: rd_data = cfg_q.reload;
            REG_KICK:   rd_data = count;
            REG_CTRL: begin
                rd_data[CTRL_HALT_BIT]      = cfg_q.halt;
                rd_data[CTRL_RBT_BIT]       = cfg_q.reboot_en;
                rd_data[POL_LSB +: POL_W]   = pol_q;
            end
            REG_STAT: begin
                rd_data[STAT_TO_BIT]  = to_flag;
                rd_data[STAT_SEC_BIT] = sec_flag;
            end
            default: ;
        endcase
    end

    assign mgmt_irq = to_flag;

    initial assert (CNT_W >= CTRL_W);

    p_irq_after_tick_r3: assert property (@(posedge clk) disable iff (!plat_rst_n)
        $rose(mgmt_irq) |-> $past(tick_en && !cfg_q.halt));
endmodule

// File: tb/wdog_two_stage_test.sv
module wdog_two_stage_test;
    localparam int W = 16;
    localparam int PRE = 2;
    localparam logic [W-1:0] RDEF = 16'd100;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b0, tick_in = 1'b0, wr_en = 1'b0;
    logic [1:0] wr_addr = '0, rd_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic mgmt_irq, plat_rst_req;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    wdog_two_stage #(.CNT_W(W), .PRESCALE(PRE), .RELOAD_DEF(RDEF)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_in(tick_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .mgmt_irq(mgmt_irq), .plat_rst_req(plat_rst_req));

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            @(negedge clk); tick_in = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic ticks(input int n);
        pulses(n * PRE);
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        rd(2'd1, v); chk("R1 count", v, RDEF);
        rd(2'd3, v); chk("R1 status", v, 0);
        rd(2'd2, v); chk("R1 ctrl", v, 0);
        chk("R1 irq", W'(mgmt_irq), 0);
        chk("R1 req", W'(plat_rst_req), 0);
    endtask

    task automatic t_countdown();
        logic [W-1:0] v;
        wr(2'd0, 5); wr(2'd1, 0);
        pulses(PRE - 1);
        rd(2'd1, v); chk("R2 partial prescale", v, 5);
        pulses(1);
        rd(2'd1, v); chk("R2 one step", v, 4);
        ticks(2);
        rd(2'd1, v); chk("R2 two steps", v, 2);
    endtask

    task automatic t_first();
        logic [W-1:0] v;
        wr(2'd0, 3); wr(2'd1, 0);
        ticks(3);
        rd(2'd1, v); chk("R3 at zero", v, 0);
        chk("R3 irq before", W'(mgmt_irq), 0);
        ticks(1);
        chk("R3 irq", W'(mgmt_irq), 1);
        rd(2'd3, v); chk("R3 status", v, 1);
        rd(2'd1, v); chk("R3 restart", v, 3);
        wr(2'd3, 0);
        rd(2'd3, v); chk("R4 zero write keeps", v, 1);
        wr(2'd3, 1);
        rd(2'd3, v); chk("R4 cleared", v, 0);
        chk("R4 irq low", W'(mgmt_irq), 0);
    endtask

    task automatic t_kick();
        logic [W-1:0] v;
        wr(2'd1, 0);
        ticks(4);
        rd(2'd3, v); chk("R5 again first only", v, 1);
        wr(2'd3, 1);
    endtask

    task automatic t_second_plain();
        logic [W-1:0] v;
        wr(2'd0, 2); wr(2'd1, 0);
        ticks(3);
        rd(2'd3, v); chk("R6 first", v, 1);
        ticks(2);
        rd(2'd3, v); chk("R6 not yet", v, 1);
        ticks(1);
        rd(2'd3, v); chk("R6 second", v, 3);
        chk("R7 no req without enable", W'(plat_rst_req), 0);
        wr(2'd3, 2);
        rd(2'd3, v); chk("R8 w1c second", v, 1);
    endtask

    task automatic t_second_reboot();
        logic [W-1:0] v;
        wr(2'd2, 16'h00A2);
        wr(2'd0, 2); wr(2'd1, 0);
        ticks(6);
        chk("R7 req", W'(plat_rst_req), 1);
        ticks(1);
        chk("R7 req held", W'(plat_rst_req), 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R7 req cleared", W'(plat_rst_req), 0);
        rd(2'd3, v); chk("R8 sticky", v, 2);
        rd(2'd2, v); chk("R10 policy kept", v, 16'h00A0);
        rd(2'd0, v); chk("R10 reload reset", v, RDEF);
    endtask

    task automatic t_halt();
        logic [W-1:0] v;
        wr(2'd0, 5); wr(2'd1, 0);
        ticks(1);
        wr(2'd2, 16'h00A1);
        ticks(3);
        rd(2'd1, v); chk("R9 frozen", v, 4);
        rd(2'd3, v); chk("R9 status kept", v, 2);
        wr(2'd2, 16'h00A0);
        ticks(1);
        rd(2'd1, v); chk("R9 resumes", v, 3);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        rd(2'd3, v); chk("R8 por clears", v, 0);
        rd(2'd2, v); chk("R10 por clears policy", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog all actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_countdown();
        t_first();
        t_kick();
        t_second_plain();
        t_second_reboot();
        t_halt();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule